// File: doc/BRIEF.md
# External Bus Yield Controller

This block decides when a processor hands its external memory bus to another master. The other master pulls an active-low request line. The block passes that line through a synchroniser and then waits for the current external access to end. At that point it turns off the processor's address, data and strobe drivers and drives an active-low grant. Outside the block, the driver-enable output gates every output buffer of the external memory interface. The contents of the bus are not modelled here.

The core shows the block two things: whether an external access is running now, and a one-cycle pulse whenever it wants to start a new one. The bus can be granted between two accesses of the same instruction, because the block only waits for the access in flight. In the normal mode the core is halted for the whole time the bus is given away. In go mode the core keeps running and is halted only when it asks for an external access. An access asked for while the bus is away is held. It is issued in the first cycle in which the drivers are back on. After release, grant goes inactive one cycle before the drivers return, so the two masters never drive the bus at the same time.

Top module: `bus_yield_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, grant_n_o = 1, drv_en_o = 1, core_halt_o = 0 and acc_go_o = 0.
- R2: req_n_i is active low and passes through two synchroniser flops. With acc_busy_i low, grant_n_o goes low at the third rising edge after req_n_i falls, and not earlier.
- R3: drv_en_o goes low in the same cycle that grant_n_o goes low. With go_mode_i = 0, core_halt_o is 1 for the whole time grant_n_o is low.
- R4: While acc_busy_i is 1, no grant is given. The grant comes at the first edge that samples acc_busy_i = 0 with the synchronised request still active.
- R5: After req_n_i rises, grant_n_o returns to 1 at the third rising edge. drv_en_o returns to 1 one cycle later, and core_halt_o drops to 0 with it unless an access is still held.
- R6: grant_n_o = 0 and drv_en_o = 1 never happen in the same cycle.
- R7: While the synchronised request is active and the bus is still owned, a pending access (core_ext_pend_i) is not issued: acc_go_o stays 0 and core_halt_o is 1. This lets the bus go between two accesses.
- R8: With go_mode_i = 1, core_halt_o stays 0 during grant until the core asks for an external access. From then on it is 1.
- R9: An access asked for while grant is active, or while the bus is held back, is remembered. acc_go_o = 1 for exactly one cycle: the first cycle in which drv_en_o is 1 again.
- R10: When the bus is owned and no request is active, a core_ext_pend_i pulse gives acc_go_o = 1 in the same cycle, with core_halt_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n_i | input | 1 | Bus request from the external master, active low, asynchronous |
| go_mode_i | input | 1 | 1: the core keeps running during grant until it needs the bus |
| acc_busy_i | input | 1 | An external memory access is in progress this cycle |
| core_ext_pend_i | input | 1 | One-cycle pulse: the core wants to start an external access |
| grant_n_o | output | 1 | Bus grant to the external master, active low |
| drv_en_o | output | 1 | Enable for the address, data and strobe output drivers |
| core_halt_o | output | 1 | Stall for the processor core |
| acc_go_o | output | 1 | The core may start its external access in this cycle |

## Verification
If the handover state is wrong, a bad grant or driver-enable value shows at the ports within the same cycle, or it breaks the rule that grant and drivers never overlap. The bench catches this by checking exact cycles: the third edge after request, the edge after a busy access ends, and the one-cycle gap on release. A lost or duplicated held access shows up as a missing or extra acc_go_o pulse in the first cycle the drivers come back on. A wrong halt decision shows up as core_halt_o being wrong in the cycle right after a go-mode access pulse.

// File: rtl/bus_yield_pkg.sv
// Shared types for the external bus yield controller.
package bus_yield_pkg;

    // Who currently has the external bus.
    typedef enum logic [1:0] {
        BY_OWN    = 2'd0,   // processor drives the bus
        BY_GRANT  = 2'd1,   // external master holds the bus
        BY_RETURN = 2'd2    // grant dropped, drivers still off for one cycle
    } by_state_e;

endpackage

// File: rtl/bus_yield_sync.sv
// Request synchroniser.
// Takes the asynchronous active-low request and gives an active-high level
// that is synchronous to clk, after STAGES flops. It assumes the request is
// held for several cycles, so no pulse stretching is done here.
module bus_yield_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_i,
    output logic rq_s_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] stage_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First flop captures the inverted asynchronous request.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= ~req_n_i;
                end
            end else begin : g_next
                // Each later flop re-samples the flop before it.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[gi] <= 1'b0;
                    else        stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    assign rq_s_o = stage_q[LAST];

endmodule

// File: rtl/bus_yield_arb.sv
// Grant state machine.
// Hands the bus to the external master at the first access boundary after
// the synchronised request appears, and hands it back with a one-cycle gap.
// It assumes acc_busy_i is high in every cycle of an external access.
module bus_yield_arb
    import bus_yield_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rq_s_i,
    input  logic acc_busy_i,
    output logic grant_n_o,
    output logic drv_en_o,
    output logic owned_o
);
    by_state_e state_q, state_d;

    // Next-state choice: yield at a boundary, and return through the gap state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BY_OWN:    if (rq_s_i && !acc_busy_i) state_d = BY_GRANT;
            BY_GRANT:  if (!rq_s_i)               state_d = BY_RETURN;
            BY_RETURN:                            state_d = BY_OWN;
            default:                              state_d = BY_OWN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BY_OWN;
        else        state_q <= state_d;
    end

    // Output decode: grant only in BY_GRANT, drivers only in BY_OWN.
    always_comb begin
        grant_n_o = (state_q != BY_GRANT);
        drv_en_o  = (state_q == BY_OWN);
        owned_o   = (state_q == BY_OWN);
    end

    assert_grant_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_n_o) |-> ($past(rq_s_i) && !$past(acc_busy_i)));

    assert_hold_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en_o && acc_busy_i) |=> grant_n_o);

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!grant_n_o && drv_en_o));

    assert_release_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_n_o) |-> !drv_en_o);

endmodule

// File: rtl/bus_yield_core_gate.sv
// Core gate.
// Decides whether the core may start an external access and whether it must
// stall. An access that cannot start is held until the bus is owned again and
// no request is pending. It assumes core_ext_pend_i is a one-cycle pulse per
// access, and that the core raises no new pulse while one is held.
module bus_yield_core_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic owned_i,
    input  logic rq_s_i,
    input  logic go_mode_i,
    input  logic pend_i,
    output logic acc_go_o,
    output logic core_halt_o
);
    logic held_q;
    logic can_issue;
    logic want;

    // Issue is allowed only while the bus is owned and not being yielded.
    always_comb begin
        can_issue   = owned_i && !rq_s_i;
        want        = pend_i || held_q;
        acc_go_o    = can_issue && want;
        core_halt_o = (!owned_i && (!go_mode_i || want))
                    || (owned_i && rq_s_i && want);
    end

    // Remember an access that could not be issued; drop it once issued.
    always_ff @(posedge clk) begin
        if (!rst_n)         held_q <= 1'b0;
        else if (can_issue) held_q <= 1'b0;
        else if (pend_i)    held_q <= 1'b1;
    end

    assert_issue_needs_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go_o |-> (owned_i && !rq_s_i));

    assert_held_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go_o |=> !held_q);

    assert_blocked_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (owned_i && rq_s_i && pend_i) |-> (core_halt_o && !acc_go_o));

    assert_go_mode_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!owned_i && go_mode_i && !pend_i && !held_q) |-> !core_halt_o);

    assert_issue_no_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go_o |-> !core_halt_o);

endmodule

// File: rtl/bus_yield_ctrl.sv
// External bus yield controller (top).
// Synchronises the external request, runs the grant state machine and gates
// core accesses. It assumes all inputs except req_n_i are synchronous to clk.
module bus_yield_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_i,
    input  logic go_mode_i,
    input  logic acc_busy_i,
    input  logic core_ext_pend_i,
    output logic grant_n_o,
    output logic drv_en_o,
    output logic core_halt_o,
    output logic acc_go_o
);
    logic rq_s;
    logic owned;

    bus_yield_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n_i (req_n_i),
        .rq_s_o  (rq_s)
    );

    bus_yield_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .rq_s_i     (rq_s),
        .acc_busy_i (acc_busy_i),
        .grant_n_o  (grant_n_o),
        .drv_en_o   (drv_en_o),
        .owned_o    (owned)
    );

    bus_yield_core_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .owned_i     (owned),
        .rq_s_i      (rq_s),
        .go_mode_i   (go_mode_i),
        .pend_i      (core_ext_pend_i),
        .acc_go_o    (acc_go_o),
        .core_halt_o (core_halt_o)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (grant_n_o && drv_en_o && !acc_go_o));

endmodule

// File: tb/bus_yield_ctrl_bench.sv
// Scoreboard bench: the driver pushes the expected port values for a given
// cycle. The monitor pops them and compares them at that cycle's falling edge.
module bus_yield_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_n_i = 1'b1;
    logic go_mode_i = 1'b0;
    logic acc_busy_i = 1'b0;
    logic core_ext_pend_i = 1'b0;
    logic grant_n_o, drv_en_o, core_halt_o, acc_go_o;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int       q_cyc[$];
    logic [3:0] q_val[$];
    string    q_tag[$];

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    bus_yield_ctrl u_bus_yield_ctrl (
        .clk(clk), .rst_n(rst_n), .req_n_i(req_n_i), .go_mode_i(go_mode_i),
        .acc_busy_i(acc_busy_i), .core_ext_pend_i(core_ext_pend_i),
        .grant_n_o(grant_n_o), .drv_en_o(drv_en_o),
        .core_halt_o(core_halt_o), .acc_go_o(acc_go_o)
    );

    // Expected value order: {grant_n, drv_en, halt, acc_go}.
    task automatic expect_at(input int c, input logic [3:0] v, input string tag);
        q_cyc.push_back(c);
        q_val.push_back(v);
        q_tag.push_back(tag);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Monitor: compare every item that is due in this cycle.
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            logic [3:0] act;
            act = {grant_n_o, drv_en_o, core_halt_o, acc_go_o};
            n_chk++;
            if (q_cyc[0] != cyc || act !== q_val[0]) begin
                n_bad++;
                $display("FAIL %s cycle %0d: actual g/d/h/a=%b expected %b (due %0d)",
                         q_tag[0], cyc, act, q_val[0], q_cyc[0]);
            end
            void'(q_cyc.pop_front());
            void'(q_val.pop_front());
            void'(q_tag.pop_front());
        end
    end

    initial begin
        int n;
        expect_at(2, 4'b1100, "R1 in reset");
        tick(4);
        rst_n = 1'b1;
        expect_at(cyc + 1, 4'b1100, "R1 after reset");
        tick(2);

        // R10: access issued at once while the bus is owned.
        n = cyc;
        core_ext_pend_i = 1'b1;
        expect_at(n + 1, 4'b1101, "R10 issue");
        tick(1);
        core_ext_pend_i = 1'b0;
        expect_at(n + 2, 4'b1100, "R10 single pulse");
        tick(2);

        // R2/R3/R5: idle request, then release.
        n = cyc;
        req_n_i = 1'b0;
        expect_at(n + 2, 4'b1100, "R2 not early");
        expect_at(n + 3, 4'b0010, "R2 R3 grant, drivers off, halt");
        tick(6);
        n = cyc;
        req_n_i = 1'b1;
        expect_at(n + 2, 4'b0010, "R5 grant still held");
        expect_at(n + 3, 4'b1010, "R5 R6 grant off, drivers still off");
        expect_at(n + 4, 4'b1100, "R5 drivers back");
        tick(6);

        // R4/R7/R9: request during a busy access, pend blocked and held.
        n = cyc;
        acc_busy_i = 1'b1;
        req_n_i = 1'b0;
        expect_at(n + 2, 4'b1100, "R4 busy, no grant");
        tick(3);
        core_ext_pend_i = 1'b1;
        expect_at(n + 4, 4'b1110, "R7 pend blocked");
        tick(1);
        core_ext_pend_i = 1'b0;
        expect_at(n + 5, 4'b1110, "R7 held, still owned");
        tick(1);
        acc_busy_i = 1'b0;
        expect_at(n + 6, 4'b0010, "R4 grant after access ends");
        tick(2);
        n = cyc;
        req_n_i = 1'b1;
        expect_at(n + 3, 4'b1010, "R5 gap cycle");
        expect_at(n + 4, 4'b1101, "R9 held issued on return");
        expect_at(n + 5, 4'b1100, "R9 one pulse only");
        tick(7);

        // R8/R9: go mode.
        n = cyc;
        go_mode_i = 1'b1;
        req_n_i = 1'b0;
        expect_at(n + 3, 4'b0000, "R8 granted, core runs");
        tick(4);
        core_ext_pend_i = 1'b1;
        expect_at(n + 5, 4'b0010, "R8 halt on access need");
        tick(1);
        core_ext_pend_i = 1'b0;
        expect_at(n + 6, 4'b0010, "R9 held during grant");
        tick(1);
        req_n_i = 1'b1;
        expect_at(n + 9, 4'b1010, "R6 gap, go mode");
        expect_at(n + 10, 4'b1101, "R9 go mode issue on return");
        expect_at(n + 11, 4'b1100, "R9 go mode single pulse");
        tick(8);

        if (q_cyc.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL scoreboard: actual %0d items left, expected 0", q_cyc.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule